// File: doc/BRIEF.md
# Conversion Sequencer with Configuration Word

This block keeps the 16-bit configuration word of a data converter and runs the conversion engine from it. A write port loads the word in one cycle, and a read port always shows it. The word holds an input-pair select, a gain code, a run-mode bit and a sample-rate code. Bit 15 has two meanings. When written, it is a request to start a conversion. When read, it reports whether a conversion is in progress. The block sends a one-cycle start pulse to the engine. It then waits for the engine's done pulse and captures the result that comes with it.

There are two run modes. In one-shot mode, a start request made while the block is powered down runs exactly one conversion, and the block then powers down again. In free-running mode, a period timer counts clock cycles and restarts the engine at a rate chosen by the sample-rate code. The period in cycles is the integer quotient of the clock frequency divided by the rate. Writing the mode back to one-shot lets the conversion in flight finish, and then the block powers down. The result leaves on a plain strobe with no ready signal, so there is no back-pressure: the consumer must take each word in the cycle it is offered. The engine is trusted to return exactly one done pulse for each start pulse.

Top module: `conv_ctrl`

## Requirements
- R1: After reset the read port returns 16'h8583, and no start pulse or result strobe is produced.
- R2: A write stores bits 14:0 of the write data. The read port returns those bits, with bit 15 showing status (1 = idle, 0 = converting).
- R3: When idle, a write with bit 15 = 1 and bit 8 = 1 raises the start output for exactly one cycle, in the cycle right after the write, and starts exactly one conversion.
- R4: Read bit 15 is 0 from the cycle after a start until the engine's done pulse, and it is 1 from the cycle after the done pulse.
- R5: A start write that arrives while a conversion is running produces no extra start pulse.
- R6: A write with bit 15 = 0 while in one-shot mode starts nothing.
- R7: When bit 8 is 0 the block runs free. Starts come one after another, spaced exactly CLK_HZ / rate(code) cycles apart, where the code is bits 7:5.
- R8: Rate codes 0 to 7 select 128, 250, 490, 920, 1600, 2400, 3300 and 3300 samples per second, so codes 6 and 7 give the same period.
- R9: Writing bit 8 back to 1 while free-running lets the current conversion complete and deliver its result. After that there are no further starts and status reads idle.
- R10: Each done pulse from a started conversion loads the engine data into the result output and raises the result strobe for one cycle, in the cycle after the done pulse.
- R11: The input-select output equals bits 14:12. The gain output equals bits 11:9, except that codes 5, 6 and 7 all come out as 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Write data |
| cfg_rd_data | output | 16 | Stored word, with live status in bit 15 |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_sel | output | 3 | Input-pair select code |
| eng_gain | output | 3 | Gain code, saturated at 5 |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_data | input | 16 | Conversion result, valid alongside eng_done |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Last captured result |

## Verification
The hardest conditions to reach from the ports are writes that land while a conversion is in flight. One is a mode change out of free-running mode. The other is a repeated start request during a one-shot conversion. The bench watches the start pulse at the ports and times each of these writes from the moment it sees a pulse, so that every such write reaches the block before the stub engine reports done. It then waits longer than a full period. Across that wait it confirms that the in-flight result still arrives and that no further start appears.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned RATE_N    = 8;
  localparam int unsigned BIT_GO    = 15;
  localparam int unsigned BIT_MODE  = 8;
  localparam int unsigned SEL_LO    = 12;
  localparam int unsigned GAIN_LO   = 9;
  localparam int unsigned RATE_LO   = 5;
  localparam logic [14:0] KEEP_RST  = 15'h0583;
  localparam logic [2:0]  GAIN_MAX  = 3'd5;

  function automatic int unsigned rate_sps(input int unsigned code);
    case (code)
      0:       return 128;
      1:       return 250;
      2:       return 490;
      3:       return 920;
      4:       return 1600;
      5:       return 2400;
      default: return 3300;
    endcase
  endfunction
endpackage

// File: rtl/conv_cfg_reg.sv
module conv_cfg_reg
  import conv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        busy,
  output logic [15:0] rd_data,
  output logic        go_req,
  output logic        mode_one,
  output logic [2:0]  rate_code,
  output logic [2:0]  sel_code,
  output logic [2:0]  gain_code
);
  logic [14:0] keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) keep_q <= KEEP_RST;
    else if (wr_en) keep_q <= wdata[14:0];
  end

  // one-shot request: start bit with one-shot mode in the same write
  assign go_req    = wr_en & wdata[BIT_GO] & wdata[BIT_MODE];
  assign rd_data   = {~busy, keep_q};
  assign mode_one  = keep_q[BIT_MODE];
  assign rate_code = keep_q[RATE_LO +: 3];
  assign sel_code  = keep_q[SEL_LO +: 3];
  assign gain_code = keep_q[GAIN_LO +: 3];
endmodule

// File: rtl/conv_rate_timer.sv
module conv_rate_timer
  import conv_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000,
  localparam int unsigned CW = $clog2(CLK_HZ / 128 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] code,
  output logic       expired
);
  logic [CW-1:0] tab [RATE_N];
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < RATE_N; g++) begin : g_tab
    assign tab[g] = CW'(CLK_HZ / rate_sps(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= tab[code] - CW'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic mode_one,
  input  logic tmr_expired,
  input  logic eng_done,
  output logic fire,
  output logic start_q,
  output logic busy
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (go_req) begin
          st_d = SEQ_ONE; fire = 1'b1;
        end else if (!mode_one) begin
          st_d = SEQ_RUN; fire = 1'b1;
        end
      end
      SEQ_ONE: if (eng_done) st_d = SEQ_IDLE;
      SEQ_RUN: begin
        if (eng_done) begin
          if (mode_one) st_d = SEQ_IDLE;
          else if (tmr_expired) fire = 1'b1;
          else st_d = SEQ_GAP;
        end
      end
      SEQ_GAP: begin
        if (mode_one) st_d = SEQ_IDLE;
        else if (tmr_expired) begin
          st_d = SEQ_RUN; fire = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= fire;
    end
  end

  assign busy = (st_q == SEQ_ONE) | (st_q == SEQ_RUN);
endmodule

// File: rtl/conv_result.sv
module conv_result #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic          valid,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= take;
      if (take) dout <= din;
    end
  end
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rd_data,
  output logic        eng_start,
  output logic [2:0]  eng_sel,
  output logic [2:0]  eng_gain,
  input  logic        eng_done,
  input  logic [15:0] eng_data,
  output logic        res_valid,
  output logic [15:0] res_data
);
  logic       busy, go_req, mode_one, fire, tmr_expired;
  logic [2:0] rate_code, gain_raw;

  conv_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .busy(busy), .rd_data(cfg_rd_data), .go_req(go_req),
    .mode_one(mode_one), .rate_code(rate_code), .sel_code(eng_sel),
    .gain_code(gain_raw)
  );

  conv_rate_timer #(.CLK_HZ(CLK_HZ)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(fire), .code(rate_code),
    .expired(tmr_expired)
  );

  conv_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .mode_one(mode_one),
    .tmr_expired(tmr_expired), .eng_done(eng_done), .fire(fire),
    .start_q(eng_start), .busy(busy)
  );

  conv_result #(.DW(WORD_W)) u_res (
    .clk(clk), .rst_n(rst_n), .take(eng_done & busy), .din(eng_data),
    .valid(res_valid), .dout(res_data)
  );

  assign eng_gain = (gain_raw > GAIN_MAX) ? GAIN_MAX : gain_raw;
endmodule

// File: rtl/conv_ctrl_chk.sv
module conv_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [15:0] cfg_rd_data,
  input logic        eng_start,
  input logic [2:0]  eng_gain,
  input logic        eng_done,
  input logic [15:0] eng_data,
  input logic        res_valid,
  input logic [15:0] res_data
);
  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_busy_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !cfg_rd_data[15]);

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cfg_rd_data[15] && cfg_rd_data[8]) |=> cfg_rd_data[15]);

  p_no_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[15] && cfg_rd_data[8] && !cfg_wr_en) |=> !eng_start);

  p_result_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cfg_rd_data[15]) |=> (res_valid && res_data == $past(eng_data)));

  p_gain_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gain <= 3'd5);
endmodule

bind conv_ctrl conv_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .eng_start(eng_start), .eng_gain(eng_gain), .eng_done(eng_done),
  .eng_data(eng_data), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/conv_ctrl_bench.sv
`timescale 1ns/1ps
module conv_ctrl_bench;
  localparam int unsigned HZ  = 200_000;
  localparam int unsigned LAT = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rd_data;
  logic        eng_start, eng_done;
  logic [2:0]  eng_sel, eng_gain;
  logic [15:0] eng_data, res_data;
  logic        res_valid;

  conv_ctrl #(.CLK_HZ(HZ)) u_conv_ctrl (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int unsigned cyc = 0;
  int n_start = 0, n_res = 0;
  int unsigned start_at [64];
  bit pend = 0;
  logic [15:0] exp_res;
  int unsigned scnt = 0;
  logic [15:0] seqv = 16'hA000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned tb_rate(input int k);
    int unsigned r [8] = '{128, 250, 490, 920, 1600, 2400, 3300, 3300};
    return r[k];
  endfunction

  // stub engine: done LAT cycles after a sampled start
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      eng_done <= 1'b0; eng_data <= '0; scnt <= 0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) scnt <= LAT;
      else if (scnt != 0) begin
        scnt <= scnt - 1;
        if (scnt == 1) begin
          eng_done <= 1'b1; eng_data <= seqv; seqv <= seqv + 16'd1;
        end
      end
    end
  end

  // monitor away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (eng_start) begin
      if (n_start < 64) start_at[n_start] = cyc;
      n_start++;
    end
    if (pend) begin
      chk(res_valid && res_data == exp_res, "R10 result", int'(res_data), int'(exp_res));
      pend = 0; n_res++;
    end else if (res_valid) chk(0, "R10 spurious strobe", 1, 0);
    if (eng_done) begin pend = 1; exp_res = eng_data; end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic wait_res();
    int guard = 0;
    while (!res_valid && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, bad, k;
    logic [15:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cfg_rd_data == 16'h8583, "R1 reset word", cfg_rd_data, 16'h8583);
    chk(!eng_start && !res_valid, "R1 quiet", {eng_start, res_valid}, 0);

    // R2 / R6 / R11 sweep of select and gain codes
    base = n_start;
    for (int s = 0; s < 8; s++) begin
      for (int g = 0; g < 8; g++) begin
        w = {1'b0, 3'(s), 3'(g), 1'b1, 3'b100, 5'b00011};
        wr(w);
        chk(cfg_rd_data == {1'b1, w[14:0]}, "R2 readback", cfg_rd_data, {1'b1, w[14:0]});
        chk(eng_sel == 3'(s), "R11 select", eng_sel, s);
        chk(eng_gain == ((g > 5) ? 3'd5 : 3'(g)), "R11 gain", eng_gain, (g > 5) ? 5 : g);
      end
    end
    repeat (3) @(negedge clk);
    chk(n_start == base, "R6 no start", n_start, base);

    // R3 / R4 one-shot
    base = n_start;
    wr(16'h8583);
    chk(eng_start == 1'b1, "R3 start pulse", eng_start, 1);
    chk(cfg_rd_data[15] == 1'b0, "R4 busy status", cfg_rd_data[15], 0);
    bad = 0;
    while (!res_valid) begin
      @(negedge clk);
      if (!res_valid && cfg_rd_data[15]) bad++;
    end
    chk(bad == 0, "R4 busy held", bad, 0);
    chk(cfg_rd_data[15] == 1'b1, "R4 idle after done", cfg_rd_data[15], 1);
    repeat (10) @(negedge clk);
    chk(n_start == base + 1, "R3 single start", n_start, base + 1);

    // R5 start while busy
    base = n_start;
    wr(16'h8583);
    wr(16'h8583);
    wait_res();
    repeat (10) @(negedge clk);
    chk(n_start == base + 1, "R5 ignored restart", n_start, base + 1);
    chk(cfg_rd_data[15] == 1'b1, "R5 idle", cfg_rd_data[15], 1);

    // R7 / R8 / R9 free-running at every rate code
    for (k = 0; k < 8; k++) begin
      int unsigned per;
      per = HZ / tb_rate(k);
      base = n_start;
      wr({1'b0, 3'b000, 3'b010, 1'b0, 3'(k), 5'b00011});
      while (n_start < base + 3) @(negedge clk);
      wr({1'b0, 3'b000, 3'b010, 1'b1, 3'(k), 5'b00011});
      chk(start_at[base + 1] - start_at[base] == per, "R7 R8 period a",
          int'(start_at[base + 1] - start_at[base]), int'(per));
      chk(start_at[base + 2] - start_at[base + 1] == per, "R7 R8 period b",
          int'(start_at[base + 2] - start_at[base + 1]), int'(per));
      repeat (per + 20) @(negedge clk);
      chk(n_start == base + 3, "R9 no further start", n_start, base + 3);
      chk(n_res == n_start, "R9 last result delivered", n_res, n_start);
      chk(cfg_rd_data[15] == 1'b1, "R9 idle", cfg_rd_data[15], 1);
    end
    finish_run();
  end
endmodule